// File: doc/BRIEF.md
# Keyboard-Style Host Port Controller

This block gives a host a two-byte register window onto a byte-oriented input device. One address is the control port. A read there returns a status byte, and a write there issues a command. The other address is the data port. A read there returns the byte held for the host, and a write there supplies a command parameter. The host learns that a byte is waiting either by polling status bit 0 or from the interrupt output. Both report the same condition.

On the device side, scancodes arrive on a valid/ready byte stream. After reset the block is disabled. In that state it takes every offered byte and discards it. An enable command makes it store incoming bytes in a single holding register. While that register is occupied it stalls the stream, so no byte is lost. A self-test command loads a fixed pass code into the holding register. A set-indicator command marks the next data-port write as an indicator pattern for three registered LED outputs.

Top module: `hostkey_port`

## Requirements
- R1: During and after synchronous reset, the status byte reads 0x00, `led_out` is 0, `irq` is 0 and `dev_ready` is 1.
- R2: Reading address 0x64 returns the status byte: bit 0 is data-waiting, bit 1 is parameter-pending, bits 7..2 read 0. Reading address 0x60 returns the holding register. Any other address reads 0x00, and writes to any other address change nothing.
- R3: Writing 0xAA to address 0x64 places 0x55 in the holding register and sets status bit 0 from the next cycle on.
- R4: While the block is disabled (from reset until 0xAE is written), `dev_ready` is 1 and every offered device byte is consumed without changing the status byte or the holding register.
- R5: Writing 0xAE to address 0x64 enables the block. From then on, each accepted device byte is stored in the holding register and sets status bit 0 from the next cycle on.
- R6: A read strobe on address 0x60 returns the most recently stored byte, and status bit 0 reads 0 from the following cycle on. Without a new byte, the holding register keeps that value.
- R7: While the block is enabled and status bit 0 is 1, `dev_ready` is 0 and the holding register does not change. Once the host has read the data port, the stalled byte is accepted.
- R8: Writing 0xED to address 0x64 sets status bit 1. The next write to address 0x60 loads `led_out` from bits 2..0 of that byte (bit 0 drives `led_out[0]`) and clears status bit 1. A data-port write while bit 1 is 0 leaves `led_out` unchanged.
- R9: `irq` is 1 exactly when status bit 0 is 1.
- R10: A command byte other than 0xAA, 0xAE and 0xED has no visible effect. The block stays disabled, and the status byte and `led_out` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host I/O byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| dev_valid | input | 1 | Device byte offered |
| dev_byte | input | 8 | Device scancode byte |
| dev_ready | output | 1 | Block can take a device byte |
| led_out | output | 3 | Registered indicator outputs |
| irq | output | 1 | Byte waiting for the host |

## Verification
The hardest state to reach is the stall. The block has to be enabled and already holding an unread byte when a second byte is offered. The host then has to read while that second byte is still pending. The stimulus enables the block and lets one byte land. It then keeps `dev_valid` high with a different byte for several cycles, checking that `dev_ready` stays low and that the held value does not change. It then issues the data read and confirms that the stalled byte lands exactly one cycle later, in order, through the expected-byte queue. The parameter-pending path is driven in the same way: a data write goes in first without the set-indicator command, then with it, then once more after the pattern has been consumed.

// File: rtl/hostkey_pkg.sv
package hostkey_pkg;

    parameter int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_SELFTEST   = 8'hAA;
    localparam byte_t OP_ENABLE     = 8'hAE;
    localparam byte_t OP_SETIND     = 8'hED;
    localparam byte_t SELFTEST_PASS = 8'h55;

    localparam int unsigned STAT_FULL_BIT = 0;
    localparam int unsigned STAT_PEND_BIT = 1;

    typedef enum logic [1:0] {
        CMD_OTHER,
        CMD_SELFTEST,
        CMD_ENABLE,
        CMD_SETIND
    } cmd_e;

    typedef struct packed {
        logic cmd_wr;
        logic data_wr;
        logic data_rd;
        cmd_e cmd;
    } host_req_t;

    function automatic cmd_e classify_cmd(input byte_t b);
        case (b)
            OP_SELFTEST: return CMD_SELFTEST;
            OP_ENABLE:   return CMD_ENABLE;
            OP_SETIND:   return CMD_SETIND;
            default:     return CMD_OTHER;
        endcase
    endfunction

    function automatic byte_t pack_status(input logic full, input logic pend);
        byte_t s;
        s = '0;
        s[STAT_FULL_BIT] = full;
        s[STAT_PEND_BIT] = pend;
        return s;
    endfunction

endpackage

// File: rtl/hostkey_decode.sv
module hostkey_decode
    import hostkey_pkg::*;
#(
    parameter int unsigned         ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]   DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0]   CTRL_PORT = 'h64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  byte_t             wdata_i,
    output host_req_t         req_o
);

    logic hit_data;
    logic hit_ctrl;

    assign hit_data = (addr_i == DATA_PORT);
    assign hit_ctrl = (addr_i == CTRL_PORT);

    always_comb begin
        req_o         = '0;
        req_o.cmd_wr  = wr_i && hit_ctrl;
        req_o.data_wr = wr_i && hit_data;
        req_o.data_rd = rd_i && hit_data;
        req_o.cmd     = (wr_i && hit_ctrl) ? classify_cmd(wdata_i) : CMD_OTHER;
    end

endmodule

// File: rtl/hostkey_ctl.sv
module hostkey_ctl
    import hostkey_pkg::*;
#(
    parameter int unsigned LED_N = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  host_req_t        req_i,
    input  logic [LED_N-1:0] led_val_i,
    output logic             enabled_o,
    output logic             pend_o,
    output logic             selftest_o,
    output logic [LED_N-1:0] led_o
);

    logic             en_q;
    logic             pend_q;
    logic [LED_N-1:0] led_q;
    logic             led_load;
    logic             set_pend;

    assign led_load   = req_i.data_wr && pend_q;
    assign set_pend   = req_i.cmd_wr && (req_i.cmd == CMD_SETIND);
    assign selftest_o = req_i.cmd_wr && (req_i.cmd == CMD_SELFTEST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= 1'b0;
        end else if (req_i.cmd_wr && req_i.cmd == CMD_ENABLE) begin
            en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= 1'b0;
        end else if (set_pend) begin
            pend_q <= 1'b1;
        end else if (led_load) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < LED_N; i++) begin : g_led
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                led_q[i] <= 1'b0;
            end else if (led_load) begin
                led_q[i] <= led_val_i[i];
            end
        end
    end

    assign enabled_o = en_q;
    assign pend_o    = pend_q;
    assign led_o     = led_q;

    // R8: indicators move only on a data write that consumes a pending parameter
    a_r8_led_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(req_i.data_wr && pend_q) |=> $stable(led_q));

    // R8: the consuming write clears the pending flag unless re-armed
    a_r8_pend_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i.data_wr && pend_q && !set_pend) |=> !pend_q);

    // R5: once enabled, the block stays enabled until reset
    a_r5_enable_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        en_q |=> en_q);

endmodule

// File: rtl/hostkey_rxhold.sv
module hostkey_rxhold
    import hostkey_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  enabled_i,
    input  logic  selftest_i,
    input  logic  take_i,
    input  logic  dev_valid_i,
    input  byte_t dev_byte_i,
    output logic  dev_ready_o,
    output logic  full_o,
    output byte_t held_o
);

    logic  full_q;
    byte_t held_q;
    logic  accept;

    assign dev_ready_o = !enabled_i || !full_q;
    assign accept      = dev_valid_i && dev_ready_o && enabled_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            full_q <= 1'b0;
            held_q <= '0;
        end else if (selftest_i) begin
            full_q <= 1'b1;
            held_q <= SELFTEST_PASS;
        end else if (accept) begin
            full_q <= 1'b1;
            held_q <= dev_byte_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign held_o = held_q;

    // R7: an occupied register is never overwritten by the device stream
    a_r7_no_overwrite: assert property (@(posedge clk_i) disable iff (rst_i)
        (full_q && !take_i && !selftest_i) |=> (full_q && $stable(held_q)));

    // R4: bytes handed over while disabled leave no trace
    a_r4_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        (dev_valid_i && dev_ready_o && !enabled_i && !selftest_i && !take_i)
        |=> ($stable(held_q) && full_q == $past(full_q)));

    // R6: a host read of a waiting byte empties the register
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_i && full_q && !selftest_i) |=> !full_q);

    // R3: self-test leaves the pass code waiting
    a_r3_selftest: assert property (@(posedge clk_i) disable iff (rst_i)
        selftest_i |=> (full_q && held_q == SELFTEST_PASS));

endmodule

// File: rtl/hostkey_port.sv
module hostkey_port
    import hostkey_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CTRL_PORT = 'h64,
    parameter int unsigned       LED_N     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              dev_valid,
    input  logic [7:0]        dev_byte,
    output logic              dev_ready,
    output logic [LED_N-1:0]  led_out,
    output logic              irq
);

    host_req_t req;
    logic      enabled;
    logic      pend;
    logic      selftest;
    logic      full;
    byte_t     held;

    hostkey_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_PORT (DATA_PORT),
        .CTRL_PORT (CTRL_PORT)
    ) u_decode (
        .addr_i  (host_addr),
        .wr_i    (host_wr),
        .rd_i    (host_rd),
        .wdata_i (host_wdata),
        .req_o   (req)
    );

    hostkey_ctl #(
        .LED_N (LED_N)
    ) u_ctl (
        .clk_i      (clk),
        .rst_i      (rst),
        .req_i      (req),
        .led_val_i  (host_wdata[LED_N-1:0]),
        .enabled_o  (enabled),
        .pend_o     (pend),
        .selftest_o (selftest),
        .led_o      (led_out)
    );

    hostkey_rxhold u_rxhold (
        .clk_i       (clk),
        .rst_i       (rst),
        .enabled_i   (enabled),
        .selftest_i  (selftest),
        .take_i      (req.data_rd),
        .dev_valid_i (dev_valid),
        .dev_byte_i  (dev_byte),
        .dev_ready_o (dev_ready),
        .full_o      (full),
        .held_o      (held)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == DATA_PORT) begin
            host_rdata = held;
        end else if (host_addr == CTRL_PORT) begin
            host_rdata = pack_status(full, pend);
        end
    end

    assign irq = full;

    // R9: an interrupt that rises announces a byte the host has not yet read
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(selftest || (dev_valid && enabled)));

endmodule

// File: tb/sim_hostkey_port.sv
module sim_hostkey_port;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       dev_valid = 1'b0;
    logic [7:0] dev_byte = 8'h00;
    logic       dev_ready;
    logic [2:0] led_out;
    logic       irq;

    int n_checks = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    hostkey_port u0 (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dev_valid  (dev_valid),
        .dev_byte   (dev_byte),
        .dev_ready  (dev_ready),
        .led_out    (led_out),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk);
        host_addr = 8'h60; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic send_dev(input logic [7:0] b);
        @(negedge clk);
        dev_valid = 1'b1; dev_byte = b;
        #1;
        while (!dev_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        dev_valid = 1'b0;
    endtask

    // Monitor: every data-port read strobe is compared with the next expected byte
    always @(negedge clk) begin
        #1;
        if (!rst && host_rd && host_addr == 8'h60) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R6 unexpected data read actual=%02h expected=none", host_rdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (host_rdata !== e) begin
                    n_err++;
                    $display("FAIL R6 data read actual=%02h expected=%02h", host_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(8'h64, v);
        chk("R1 status", v, 8'h00);
        chk("R1 led", {5'b0, led_out}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 dev_ready", {7'b0, dev_ready}, 8'h01);

        // R4 disabled: byte consumed and dropped
        send_dev(8'h1C);
        peek(8'h64, v);
        chk("R4 status after dropped byte", v, 8'h00);
        peek(8'h60, v);
        chk("R4 holding reg after dropped byte", v, 8'h00);

        // R10 unknown command has no effect
        host_write(8'h64, 8'h12);
        peek(8'h64, v);
        chk("R10 status after unknown cmd", v, 8'h00);
        send_dev(8'h22);
        peek(8'h64, v);
        chk("R10 still disabled", v, 8'h00);
        chk("R10 led", {5'b0, led_out}, 8'h00);

        // R2 other addresses
        host_write(8'h61, 8'hED);
        peek(8'h64, v);
        chk("R2 write to other address ignored", v, 8'h00);
        peek(8'h70, v);
        chk("R2 other address reads zero", v, 8'h00);

        // R3 self-test, R9 irq, R6 clear
        exp_q.push_back(8'h55);
        host_write(8'h64, 8'hAA);
        peek(8'h64, v);
        chk("R3 status after self-test", v, 8'h01);
        chk("R9 irq with byte waiting", {7'b0, irq}, 8'h01);
        read_data();
        peek(8'h64, v);
        chk("R6 status after read", v, 8'h00);
        chk("R9 irq after read", {7'b0, irq}, 8'h00);

        // R5 enable and store
        host_write(8'h64, 8'hAE);
        exp_q.push_back(8'h1C);
        send_dev(8'h1C);
        peek(8'h64, v);
        chk("R5 status after byte", v, 8'h01);
        read_data();

        // R7 stall while full
        exp_q.push_back(8'h2A);
        exp_q.push_back(8'h3B);
        send_dev(8'h2A);
        @(negedge clk);
        dev_valid = 1'b1; dev_byte = 8'h3B;
        for (int k = 0; k < 3; k++) begin
            peek(8'h60, v);
            chk("R7 held byte during stall", v, 8'h2A);
            chk("R7 dev_ready low while full", {7'b0, dev_ready}, 8'h00);
        end
        read_data();
        #1;
        chk("R7 dev_ready after read", {7'b0, dev_ready}, 8'h01);
        @(negedge clk);
        dev_valid = 1'b0;
        peek(8'h64, v);
        chk("R7 stalled byte landed", v, 8'h01);
        read_data();
        peek(8'h60, v);
        chk("R6 latest byte kept after read", v, 8'h3B);

        // R8 indicator parameter
        host_write(8'h60, 8'h07);
        peek(8'h64, v);
        chk("R8 led unchanged without pending", {5'b0, led_out}, 8'h00);
        host_write(8'h64, 8'hED);
        peek(8'h64, v);
        chk("R8 pending bit set", v, 8'h02);
        host_write(8'h60, 8'hF5);
        peek(8'h64, v);
        chk("R8 led loaded", {5'b0, led_out}, 8'h05);
        chk("R8 pending cleared", v, 8'h00);
        host_write(8'h60, 8'h02);
        peek(8'h64, v);
        chk("R8 led kept after parameter consumed", {5'b0, led_out}, 8'h05);

        chk("R6 all expected reads seen", exp_q.size() == 0 ? 8'h01 : 8'h00, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule